// File: doc/BRIEF.md
# Prebyte-Aware Opcode Pre-Decoder

This block sits behind an instruction fetch unit and watches an 8-bit instruction stream one byte at a time. The opcode space has four pages. Three escape bytes lead from the primary page to three sparse auxiliary pages. Any other leading byte is an opcode on the primary page. The block follows this escape state. It looks up whether the opcode is defined on the selected page and which addressing mode it uses. From that it works out how many operand bytes follow, and it counts them off as they arrive.

When the last byte of an instruction has been taken, the block raises a one-cycle completion strobe with a summary of the instruction:

- the page number,
- the opcode,
- the addressing-mode class,
- the total length in bytes,
- an illegal-opcode flag,
- a flag marking instructions that use the second index register, so the caller can charge one extra cycle for them.

The fetch unit uses the strobe to move to the next instruction boundary. Operand bytes are only counted and are never decoded.

Top module: `prebyte_predecoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drops any partly received instruction. `instrDone` is low in the cycle after that edge, and the next accepted byte starts a page-0 instruction.
- R2: A leading byte of 0x18, 0x1A or 0xCD selects page 1, 2 or 3 and is reported as `instrPage` = 1, 2 or 3. Any other leading byte is a page-0 opcode (`instrPage` = 0). The escape byte counts toward `instrLength`.
- R3: `instrLength` equals the escape byte (if any) plus one opcode byte plus the operand bytes, always 1 to 5. Operand bytes are never interpreted, even when they equal an escape value.
- R4: An undefined code completes on the opcode byte with `instrIllegal` = 1, `instrMode` = 0, `instrSecondIdx` = 0 and a length of 1 on page 0 or 2 on an auxiliary page.
- R5: Exactly 233 codes are defined on page 0, excluding the three escape values. Pages 1, 2 and 3 define exactly 64, 7 and 4 codes. For example, 0x42 on page 0 is undefined.
- R6: Every defined page-0 opcode with upper nibble 2 is a relative branch (`instrMode` = 1) with a length of 2.
- R7: Mode encoding is 0 inherent, 1 relative, 2 immediate, 3 direct, 4 indexed, 5 extended. For opcodes 0x80 to 0xFF, opcode bits 5:4 select the mode: 00 immediate, 01 direct, 10 indexed, 11 extended. The exceptions are 0x8D on page 0, which is relative, and 0x8F on pages 0 and 1 and 0xCF on page 0, which are inherent.
- R8: An immediate operand is two bytes when the opcode's low nibble is 3, C or E (16-bit registers), and one byte otherwise.
- R9: The page-0 bit-manipulation codes use direct mode at 0x12 to 0x15 and indexed mode at 0x1C to 0x1F; the page-1 codes 0x1C to 0x1F are indexed. Set and clear forms carry an address byte and a mask byte. Branch-on-bit forms (low nibble 2, 3, E or F) carry a third, offset byte.
- R10: `instrSecondIdx` is 1 for every defined code on pages 1 and 3, and for the page-2 codes whose low nibble is not 3. It is 0 for all other codes.
- R11: An escape value received directly after an escape byte is decoded as an opcode on the already selected page, never as a second escape.
- R12: `instrDone` is high for exactly one cycle: the cycle after the clock edge that accepts the final byte. Bytes presented while `byteValid` is low are not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | `byteData` carries a stream byte this cycle |
| byteData | input | 8 | Instruction stream byte |
| instrDone | output | 1 | One-cycle strobe: an instruction has been fully received |
| instrPage | output | 2 | Opcode page of the completed instruction |
| instrOpcode | output | 8 | Opcode byte (escape byte excluded) |
| instrMode | output | 3 | Addressing-mode class (encoding in R7) |
| instrLength | output | 3 | Total instruction length in bytes |
| instrIllegal | output | 1 | Opcode is undefined on its page |
| instrSecondIdx | output | 1 | Instruction uses the second index register |

## Verification
A vector table sends single-byte opcodes, relative branches, short and wide immediates, direct, indexed and extended forms, and both bit-manipulation shapes. Each is sent plain and behind each escape byte. The table separates the per-page mode rules, the operand-count rules and the second-index flag. Nested escapes and undefined codes in the table show that the page is held and that rejection ends an instruction early. Fillers equal to an escape value test that operands are never decoded. A sweep over all 256 codes on every page checks that the defined count per page is exact and that the reported length always equals the number of bytes consumed. Directed tests cover:
- a reset after an escape byte and a reset after a partial operand,
- idle gaps inside an instruction,
- back-to-back one-byte instructions, which show that the strobe lasts one cycle.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  localparam int OP_W    = 8;
  localparam int NUM_AUX = 3;
  localparam int PAGE_W  = $clog2(NUM_AUX + 1);
  localparam int LEN_W   = 3;
  localparam int NOPS_W  = 2;

  typedef enum logic [2:0] {
    MODE_INH = 3'd0,
    MODE_REL = 3'd1,
    MODE_IMM = 3'd2,
    MODE_DIR = 3'd3,
    MODE_IDX = 3'd4,
    MODE_EXT = 3'd5
  } addrMode_e;

  typedef struct packed {
    logic              legal;
    addrMode_e         mode;
    logic [NOPS_W-1:0] nOps;
    logic              secondIdx;
  } decInfo_t;

  typedef struct packed {
    logic takePrebyte;
    logic latchOp;
    logic countDown;
    logic emitNow;
    logic emitHeld;
  } ctrlStrobe_t;

endpackage

// File: rtl/pdec_lookup.sv
module pdec_lookup
  import pdec_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [OP_W-1:0]   opcode,
  output decInfo_t          info
);

  logic [3:0] hi, lo;
  logic       legal, wideImm, bitOp, brBit;
  addrMode_e  mode;
  logic [NOPS_W-1:0] nOps;

  assign hi = opcode[7:4];
  assign lo = opcode[3:0];

  // Per-page legality
  always_comb begin
    legal = 1'b0;
    case (page)
      2'd0: legal = !((hi inside {4'h4, 4'h5, 4'h6, 4'h7} && lo inside {4'h1, 4'h2, 4'h5, 4'hB})
                   || (hi inside {4'h4, 4'h5} && lo == 4'hE)
                   || (hi inside {4'h8, 4'hC} && lo == 4'h7)
                   || (opcode inside {8'h18, 8'h1A, 8'hCD}));
      2'd1: begin
        case (hi)
          4'h0:       legal = lo inside {4'h8, 4'h9};
          4'h1:       legal = lo >= 4'hC;
          4'h3:       legal = lo inside {4'h0, 4'h5, 4'h8, 4'hA, 4'hC};
          4'h6:       legal = !(lo inside {4'h1, 4'h2, 4'h5, 4'hB});
          4'hA, 4'hE: legal = 1'b1;
          4'h8:       legal = lo inside {4'hC, 4'hF};
          4'h9, 4'hB: legal = lo == 4'hC;
          4'hC:       legal = lo == 4'hE;
          4'hD, 4'hF: legal = lo inside {4'hE, 4'hF};
          default:    legal = 1'b0;
        endcase
      end
      2'd2:    legal = (lo == 4'h3 && hi[3] && !hi[2]) || (opcode inside {8'hAC, 8'hEE, 8'hEF});
      default: legal = opcode inside {8'hA3, 8'hAC, 8'hEE, 8'hEF};
    endcase
  end

  // Addressing-mode class
  always_comb begin
    mode = MODE_INH;
    if (hi[3]) begin
      if (page == '0 && opcode == 8'h8D)                          mode = MODE_REL;
      else if (opcode == 8'h8F || (page == '0 && opcode == 8'hCF)) mode = MODE_INH;
      else begin
        case (opcode[5:4])
          2'b00:   mode = MODE_IMM;
          2'b01:   mode = MODE_DIR;
          2'b10:   mode = MODE_IDX;
          default: mode = MODE_EXT;
        endcase
      end
    end else begin
      case (hi)
        4'h1: begin
          if (page != '0)                                    mode = MODE_IDX;
          else if (lo inside {4'h2, 4'h3, 4'h4, 4'h5})       mode = MODE_DIR;
          else if (lo >= 4'hC)                               mode = MODE_IDX;
          else                                               mode = MODE_INH;
        end
        4'h2:    mode = (page == '0) ? MODE_REL : MODE_INH;
        4'h6:    mode = MODE_IDX;
        4'h7:    mode = MODE_EXT;
        default: mode = MODE_INH;
      endcase
    end
  end

  // Operand byte count
  always_comb begin
    wideImm = lo inside {4'h3, 4'hC, 4'hE};
    bitOp   = (hi == 4'h1) && (mode != MODE_INH);
    brBit   = bitOp && (lo inside {4'h2, 4'h3, 4'hE, 4'hF});
    case (mode)
      MODE_INH: nOps = 2'd0;
      MODE_EXT: nOps = 2'd2;
      MODE_IMM: nOps = wideImm ? 2'd2 : 2'd1;
      default:  nOps = 2'd1;
    endcase
    if (bitOp) nOps = brBit ? 2'd3 : 2'd2;
  end

  always_comb begin
    info.legal     = legal;
    info.mode      = legal ? mode : MODE_INH;
    info.nOps      = legal ? nOps : '0;
    info.secondIdx = legal && (page == 2'd1 || page == 2'd3 || (page == 2'd2 && lo != 4'h3));
  end

endmodule

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        byteValid,
  input  logic        isPrebyte,
  input  logic        needOps,
  input  logic        lastOp,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {S_START, S_PAGED, S_OPERAND} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (byteValid) begin
      case (state)
        S_START: begin
          if (isPrebyte) begin
            strobe.takePrebyte = 1'b1;
            stateNext          = S_PAGED;
          end else if (needOps) begin
            strobe.latchOp = 1'b1;
            stateNext      = S_OPERAND;
          end else begin
            strobe.emitNow = 1'b1;
          end
        end
        S_PAGED: begin
          if (needOps) begin
            strobe.latchOp = 1'b1;
            stateNext      = S_OPERAND;
          end else begin
            strobe.emitNow = 1'b1;
            stateNext      = S_START;
          end
        end
        default: begin
          strobe.countDown = 1'b1;
          if (lastOp) begin
            strobe.emitHeld = 1'b1;
            stateNext       = S_START;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_START;
    else     state <= stateNext;
  end

endmodule

// File: rtl/pdec_datapath.sv
module pdec_datapath
  import pdec_pkg::*;
#(
  parameter logic [OP_W*NUM_AUX-1:0] PREBYTES = 24'hCD1A18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   byteData,
  input  ctrlStrobe_t       strobe,
  input  decInfo_t          info,
  output logic [PAGE_W-1:0] curPage,
  output logic              isPrebyte,
  output logic              needOps,
  output logic              lastOp,
  output logic              outDone,
  output logic [PAGE_W-1:0] outPage,
  output logic [OP_W-1:0]   outOp,
  output logic [2:0]        outMode,
  output logic [LEN_W-1:0]  outLen,
  output logic              outIll,
  output logic              outSec
);

  logic [NUM_AUX-1:0]  preHit;
  logic [PAGE_W-1:0]   preIdx;
  logic [PAGE_W-1:0]   pageReg;
  logic [OP_W-1:0]     heldOp;
  decInfo_t            heldInfo;
  logic [NOPS_W-1:0]   remaining;

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_pre
    assign preHit[g] = (byteData == PREBYTES[OP_W*g +: OP_W]);
  end

  always_comb begin
    preIdx = '0;
    for (int i = 0; i < NUM_AUX; i++)
      if (preHit[i]) preIdx = PAGE_W'(i + 1);
  end

  function automatic logic [LEN_W-1:0] lenOf(input logic [PAGE_W-1:0] pg,
                                             input logic [NOPS_W-1:0] n);
    return LEN_W'(1) + LEN_W'(pg != '0) + LEN_W'(n);
  endfunction

  assign curPage   = pageReg;
  assign isPrebyte = |preHit;
  assign needOps   = info.nOps != '0;
  assign lastOp    = remaining == NOPS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pageReg   <= '0;
      heldOp    <= '0;
      heldInfo  <= '0;
      remaining <= '0;
      outDone   <= 1'b0;
      outPage   <= '0;
      outOp     <= '0;
      outMode   <= '0;
      outLen    <= '0;
      outIll    <= 1'b0;
      outSec    <= 1'b0;
    end else begin
      outDone <= strobe.emitNow | strobe.emitHeld;
      if (strobe.takePrebyte) pageReg <= preIdx;
      if (strobe.latchOp) begin
        heldOp    <= byteData;
        heldInfo  <= info;
        remaining <= info.nOps;
      end
      if (strobe.countDown) remaining <= remaining - NOPS_W'(1);
      if (strobe.emitNow) begin
        outPage <= pageReg;
        outOp   <= byteData;
        outMode <= info.mode;
        outLen  <= lenOf(pageReg, info.nOps);
        outIll  <= !info.legal;
        outSec  <= info.secondIdx;
        pageReg <= '0;
      end
      if (strobe.emitHeld) begin
        outPage <= pageReg;
        outOp   <= heldOp;
        outMode <= heldInfo.mode;
        outLen  <= lenOf(pageReg, heldInfo.nOps);
        outIll  <= !heldInfo.legal;
        outSec  <= heldInfo.secondIdx;
        pageReg <= '0;
      end
    end
  end

endmodule

// File: rtl/prebyte_predecoder.sv
module prebyte_predecoder
  import pdec_pkg::*;
#(
  parameter logic [OP_W*NUM_AUX-1:0] PREBYTES = 24'hCD1A18
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        instrDone,
  output logic [1:0]  instrPage,
  output logic [7:0]  instrOpcode,
  output logic [2:0]  instrMode,
  output logic [2:0]  instrLength,
  output logic        instrIllegal,
  output logic        instrSecondIdx
);

  ctrlStrobe_t       strobe;
  decInfo_t          info;
  logic [PAGE_W-1:0] curPage;
  logic              isPrebyte, needOps, lastOp;

  pdec_lookup lookup_i (
    .page   (curPage),
    .opcode (byteData),
    .info   (info)
  );

  pdec_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .byteValid (byteValid),
    .isPrebyte (isPrebyte),
    .needOps   (needOps),
    .lastOp    (lastOp),
    .strobe    (strobe)
  );

  pdec_datapath #(.PREBYTES(PREBYTES)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .byteData  (byteData),
    .strobe    (strobe),
    .info      (info),
    .curPage   (curPage),
    .isPrebyte (isPrebyte),
    .needOps   (needOps),
    .lastOp    (lastOp),
    .outDone   (instrDone),
    .outPage   (instrPage),
    .outOp     (instrOpcode),
    .outMode   (instrMode),
    .outLen    (instrLength),
    .outIll    (instrIllegal),
    .outSec    (instrSecondIdx)
  );

endmodule

// File: rtl/pdec_checker.sv
module pdec_checker
  import pdec_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       byteValid,
  input logic       instrDone,
  input logic [1:0] instrPage,
  input logic [7:0] instrOpcode,
  input logic [2:0] instrMode,
  input logic [2:0] instrLength,
  input logic       instrIllegal,
  input logic       instrSecondIdx
);

  logic pastRst;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (pastRst)
      p_reset_quiet_r1: assert (!instrDone);
  end

  p_page_len_r2: assert property (@(posedge clk) disable iff (rst)
    (instrDone && instrPage != 2'd0) |-> instrLength >= 3'd2);

  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    instrDone |-> (instrLength >= 3'd1 && instrLength <= 3'd5));

  p_illegal_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (instrDone && instrIllegal) |->
      (instrMode == 3'd0 && !instrSecondIdx &&
       instrLength == ((instrPage == 2'd0) ? 3'd1 : 3'd2)));

  p_branch_column_r6: assert property (@(posedge clk) disable iff (rst)
    (instrDone && !instrIllegal && instrPage == 2'd0 && instrOpcode[7:4] == 4'h2) |->
      (instrMode == 3'(MODE_REL) && instrLength == 3'd2));

  p_imm_width_r8: assert property (@(posedge clk) disable iff (rst)
    (instrDone && instrMode == 3'(MODE_IMM)) |->
      ((instrLength - 3'(instrPage != 2'd0)) inside {3'd2, 3'd3}));

  p_second_idx_page_r10: assert property (@(posedge clk) disable iff (rst)
    (instrDone && instrSecondIdx) |-> instrPage != 2'd0);

  p_done_after_byte_r12: assert property (@(posedge clk) disable iff (rst)
    instrDone |-> $past(byteValid));

endmodule

bind prebyte_predecoder pdec_checker chk_i (
  .clk            (clk),
  .rst            (rst),
  .byteValid      (byteValid),
  .instrDone      (instrDone),
  .instrPage      (instrPage),
  .instrOpcode    (instrOpcode),
  .instrMode      (instrMode),
  .instrLength    (instrLength),
  .instrIllegal   (instrIllegal),
  .instrSecondIdx (instrSecondIdx)
);

// File: tb/prebyte_predecoder_tb.sv
`timescale 1ns/1ps
module prebyte_predecoder_tb_top;

  localparam logic [2:0] M_INH = 3'd0, M_REL = 3'd1, M_IMM = 3'd2,
                         M_DIR = 3'd3, M_IDX = 3'd4, M_EXT = 3'd5;
  localparam int NVEC = 40;
  // {page[17:16], opcode[15:8], length[7:5], mode[4:2], illegal[1], secondIdx[0]}
  localparam logic [17:0] VECS [NVEC] = '{
    {2'd0, 8'h01, 3'd1, M_INH, 1'b0, 1'b0},
    {2'd0, 8'h26, 3'd2, M_REL, 1'b0, 1'b0},
    {2'd0, 8'h86, 3'd2, M_IMM, 1'b0, 1'b0},
    {2'd0, 8'hCC, 3'd3, M_IMM, 1'b0, 1'b0},
    {2'd0, 8'h8E, 3'd3, M_IMM, 1'b0, 1'b0},
    {2'd0, 8'hC3, 3'd3, M_IMM, 1'b0, 1'b0},
    {2'd0, 8'h96, 3'd2, M_DIR, 1'b0, 1'b0},
    {2'd0, 8'hA6, 3'd2, M_IDX, 1'b0, 1'b0},
    {2'd0, 8'hB6, 3'd3, M_EXT, 1'b0, 1'b0},
    {2'd0, 8'h12, 3'd4, M_DIR, 1'b0, 1'b0},
    {2'd0, 8'h15, 3'd3, M_DIR, 1'b0, 1'b0},
    {2'd0, 8'h1E, 3'd4, M_IDX, 1'b0, 1'b0},
    {2'd0, 8'h1D, 3'd3, M_IDX, 1'b0, 1'b0},
    {2'd0, 8'h42, 3'd1, M_INH, 1'b1, 1'b0},
    {2'd0, 8'h87, 3'd1, M_INH, 1'b1, 1'b0},
    {2'd0, 8'h5E, 3'd1, M_INH, 1'b1, 1'b0},
    {2'd0, 8'h8D, 3'd2, M_REL, 1'b0, 1'b0},
    {2'd0, 8'hCF, 3'd1, M_INH, 1'b0, 1'b0},
    {2'd0, 8'h7E, 3'd3, M_EXT, 1'b0, 1'b0},
    {2'd0, 8'h3A, 3'd1, M_INH, 1'b0, 1'b0},
    {2'd1, 8'h08, 3'd2, M_INH, 1'b0, 1'b1},
    {2'd1, 8'h1F, 3'd5, M_IDX, 1'b0, 1'b1},
    {2'd1, 8'h1C, 3'd4, M_IDX, 1'b0, 1'b1},
    {2'd1, 8'h8C, 3'd4, M_IMM, 1'b0, 1'b1},
    {2'd1, 8'hCE, 3'd4, M_IMM, 1'b0, 1'b1},
    {2'd1, 8'hA6, 3'd3, M_IDX, 1'b0, 1'b1},
    {2'd1, 8'h8F, 3'd2, M_INH, 1'b0, 1'b1},
    {2'd1, 8'h3A, 3'd2, M_INH, 1'b0, 1'b1},
    {2'd1, 8'h00, 3'd2, M_INH, 1'b1, 1'b0},
    {2'd1, 8'h18, 3'd2, M_INH, 1'b1, 1'b0},
    {2'd1, 8'h9C, 3'd3, M_DIR, 1'b0, 1'b1},
    {2'd1, 8'hFF, 3'd4, M_EXT, 1'b0, 1'b1},
    {2'd2, 8'h83, 3'd4, M_IMM, 1'b0, 1'b0},
    {2'd2, 8'hB3, 3'd4, M_EXT, 1'b0, 1'b0},
    {2'd2, 8'hEE, 3'd3, M_IDX, 1'b0, 1'b1},
    {2'd2, 8'h1A, 3'd2, M_INH, 1'b1, 1'b0},
    {2'd3, 8'hAC, 3'd3, M_IDX, 1'b0, 1'b1},
    {2'd3, 8'h83, 3'd2, M_INH, 1'b1, 1'b0},
    {2'd3, 8'hCD, 3'd2, M_INH, 1'b1, 1'b0},
    {2'd0, 8'hDF, 3'd2, M_DIR, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       instrDone, instrIllegal, instrSecondIdx;
  logic [1:0] instrPage;
  logic [7:0] instrOpcode;
  logic [2:0] instrMode, instrLength;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  prebyte_predecoder dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteData(byteData),
    .instrDone(instrDone), .instrPage(instrPage), .instrOpcode(instrOpcode),
    .instrMode(instrMode), .instrLength(instrLength),
    .instrIllegal(instrIllegal), .instrSecondIdx(instrSecondIdx)
  );

  function automatic logic [7:0] escOf(input logic [1:0] pg);
    case (pg)
      2'd1:    return 8'h18;
      2'd2:    return 8'h1A;
      default: return 8'hCD;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one byte accepted, then sample in the following cycle
  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
    byteData  = 8'h18;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst       = 1'b1;
    byteValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic scanPage(input logic [1:0] pg, input int expLegal);
    int legalCnt = 0;
    int lenBad   = 0;
    int hung     = 0;
    for (int op = 0; op < 256; op++) begin
      int used = 0;
      if (pg == 2'd0 && (op == 8'h18 || op == 8'h1A || op == 8'hCD)) continue;
      if (pg != 2'd0) begin pushByte(escOf(pg)); used++; end
      pushByte(8'(op)); used++;
      while (!instrDone && used < 6) begin pushByte(8'hCD); used++; end
      if (!instrDone) hung++;
      else begin
        if (int'(instrLength) != used) lenBad++;
        if (!instrIllegal) legalCnt++;
      end
    end
    chk(legalCnt == expLegal, "R5", $sformatf("defined count page %0d", pg), legalCnt, expLegal);
    chk(lenBad == 0, "R3", $sformatf("length vs bytes consumed page %0d", pg), lenBad, 0);
    chk(hung == 0, "R12", $sformatf("instructions never completed page %0d", pg), hung, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(instrDone == 1'b0, "R1", "done after reset", instrDone, 0);
    chk(instrPage == 2'd0, "R1", "page after reset", instrPage, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] pg;
      logic [7:0] op;
      int total, pre;
      bit early;
      pg    = VECS[v][17:16];
      op    = VECS[v][15:8];
      total = int'(VECS[v][7:5]);
      pre   = (pg != 2'd0) ? 1 : 0;
      early = 1'b0;
      for (int j = 0; j < total; j++) begin
        logic [7:0] b;
        if (j < pre)       b = escOf(pg);
        else if (j == pre) b = op;
        else               b = 8'hCD;
        pushByte(b);
        if (j < total - 1 && instrDone) early = 1'b1;
      end
      chk(!early, "R12", $sformatf("vec %0d early done", v), early, 0);
      chk(instrDone == 1'b1, "R12", $sformatf("vec %0d done strobe", v), instrDone, 1);
      chk(instrPage == pg, "R2", $sformatf("vec %0d page", v), instrPage, pg);
      chk(instrOpcode == op, "R11", $sformatf("vec %0d opcode", v), instrOpcode, op);
      chk(instrLength == VECS[v][7:5], "R3", $sformatf("vec %0d length", v), instrLength, VECS[v][7:5]);
      chk(instrMode == VECS[v][4:2], "R7", $sformatf("vec %0d mode", v), instrMode, VECS[v][4:2]);
      chk(instrIllegal == VECS[v][1], "R4", $sformatf("vec %0d illegal", v), instrIllegal, VECS[v][1]);
      chk(instrSecondIdx == VECS[v][0], "R10", $sformatf("vec %0d second index", v), instrSecondIdx, VECS[v][0]);
    end

    // R1: reset after an escape byte
    pushByte(8'h18);
    doReset();
    chk(instrDone == 1'b0, "R1", "done in cycle after reset", instrDone, 0);
    pushByte(8'h08);
    chk(instrDone && instrPage == 2'd0 && instrLength == 3'd1 && !instrSecondIdx, "R1",
        "escape dropped by reset", {instrDone, instrPage, instrLength}, {1'b1, 2'd0, 3'd1});

    // R1: reset inside the operand bytes
    pushByte(8'hB6);
    pushByte(8'h00);
    doReset();
    pushByte(8'h01);
    chk(instrDone && instrOpcode == 8'h01 && instrLength == 3'd1, "R1",
        "operand count dropped by reset", {instrDone, instrOpcode}, {1'b1, 8'h01});

    // R12: idle gap with junk on the data lines
    pushByte(8'h86);
    begin
      bit gapDone = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        byteData = 8'h55;
        if (instrDone) gapDone = 1'b1;
      end
      chk(!gapDone, "R12", "done during idle gap", gapDone, 0);
    end
    pushByte(8'h44);
    chk(instrDone && instrOpcode == 8'h86 && instrLength == 3'd2 && instrMode == M_IMM, "R8",
        "short immediate across gap", {instrDone, instrOpcode, instrLength}, {1'b1, 8'h86, 3'd2});
    @(negedge clk);
    chk(instrDone == 1'b0, "R12", "strobe lasts one cycle", instrDone, 0);

    // R12: back-to-back single-byte instructions
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = 8'h01;
    @(negedge clk);
    byteData  = 8'h3A;
    chk(instrDone && instrOpcode == 8'h01, "R12", "first of back-to-back", {instrDone, instrOpcode}, {1'b1, 8'h01});
    @(negedge clk);
    byteValid = 1'b0;
    chk(instrDone && instrOpcode == 8'h3A, "R12", "second of back-to-back", {instrDone, instrOpcode}, {1'b1, 8'h3A});

    // R6 and R9 via sweep-independent directed codes
    pushByte(8'h2F);
    pushByte(8'h00);
    chk(instrMode == M_REL && instrLength == 3'd2, "R6", "branch column", {instrMode, instrLength}, {M_REL, 3'd2});
    pushByte(8'h13);
    pushByte(8'h18);
    pushByte(8'h1A);
    pushByte(8'hCD);
    chk(instrDone && instrLength == 3'd4 && instrMode == M_DIR, "R9", "branch-on-bit direct",
        {instrDone, instrLength}, {1'b1, 3'd4});

    // R5: full sweep on all pages
    scanPage(2'd0, 233);
    scanPage(2'd1, 64);
    scanPage(2'd2, 7);
    scanPage(2'd3, 4);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #750000;
    nFails++;
    $display("FAIL R12 watchdog expired: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule